// File: doc/BRIEF.md
# Lane Metaframe Synchronizer

This block sits on one receive lane behind the block-lock logic. Each cycle it may take one 64-bit word, marked as a control or a data word. It finds the metaframe boundary by looking for the synchronization word. Once it trusts that boundary, it checks the control words that must appear at fixed positions in every metaframe. It raises single-cycle flags for misplaced or malformed words. It also keeps the two-bit lane status carried in the diagnostic word, so that the local transmit framer can echo it.

The metaframe is `MF_LEN` words long. Position 0 holds the synchronization word, position 1 the scrambler-state word, position 2 the skip word, and position `MF_LEN-1` the diagnostic word. Word types are coded as follows:

- **Synchronization word:** `word_ctrl=1` and a data value equal to `64'h78F6_78F6_78F6_78F6`.
- **Other control words:** `word_ctrl=1`, with a type code in bits [63:58]:
  - scrambler state: `6'b001010`
  - skip: `6'b000111`
  - diagnostic: `6'b011001`
- **Well-formed skip word:** the skip type code, plus bits [57:0] equal to `{2'b10, 56'h1E1E1E1E1E1E1E}`.

Descrambling, diagnostic CRC, the block-lock machine and lane deskew are handled elsewhere.

The tracking machine has three states:

- **SEARCH:** on a valid synchronization word, go to VERIFY. This counts as the first good synchronization word, and the position becomes 1.
- **VERIFY:** at every position-0 word, a synchronization word increments the good count. The fourth one moves the machine to LOCKED. A mismatch returns it to SEARCH.
- **LOCKED:** a position-0 mismatch increments the miss count. The fourth consecutive miss returns the machine to SEARCH. A match clears the count.

From any state, a low `blk_lock` forces SEARCH. Positions advance only on valid words.

Top module: `ifs_frame_sync`

## Requirements
- R1: `frame_lock` rises after the fourth consecutive synchronization word seen at metaframe spacing (SEARCH, then VERIFY, then LOCKED). A non-synchronization word at position 0 during VERIFY restarts the search.
- R2: In LOCKED, a valid word at position 0 that is not the synchronization word makes `sync_err` high for exactly the cycle after that word.
- R3: In LOCKED, a control word with the skip type code at any position other than 2 makes `skip_ins` high in the cycle after it.
- R4: In LOCKED, a word at position 2 that is not a control word with the skip type code makes `pyld_ins` high in the cycle after it.
- R5: In LOCKED, a skip-typed control word at position 2 whose bits [57:0] differ from the skip pattern makes `skip_err` high in the cycle after it.
- R6: In LOCKED, a word at position `MF_LEN-1` that is not a control word with the diagnostic type code makes `diag_err` high in the cycle after it.
- R7: `lane_status` resets to `2'b00`. It loads bits [33:32] of a well-typed diagnostic word received at position `MF_LEN-1` in LOCKED. It holds its value at all other times, including cycles without a valid word.
- R8: While `blk_lock` is low, the following hold in the next cycle:
  - `sync_err`, `skip_err` and `diag_err` are held at 1;
  - `skip_ins` and `pyld_ins` are 0;
  - the machine returns to SEARCH, so `frame_lock` is 0;
  - `lane_status` keeps its value.
- R9: In LOCKED, `frame_lock` stays high through up to three consecutive synchronization misses. A matching synchronization word clears the miss count. The fourth consecutive miss drops `frame_lock`, and that fourth miss is still flagged on `sync_err`.
- R10: With `blk_lock` high and the machine not in LOCKED, no error or insertion flag is raised for any word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| blk_lock | input | 1 | Lane block lock level |
| word_valid | input | 1 | A word is present this cycle |
| word_ctrl | input | 1 | 1 = control word, 0 = data word |
| word_data | input | 64 | Received word |
| frame_lock | output | 1 | Machine is in LOCKED |
| sync_err | output | 1 | Synchronization word error |
| skip_ins | output | 1 | Skip word outside the skip slot |
| pyld_ins | output | 1 | Non-skip word in the skip slot |
| skip_err | output | 1 | Malformed skip word in the skip slot |
| diag_err | output | 1 | Diagnostic word error |
| lane_status | output | 2 | Last captured diagnostic lane status |

## Verification
Some properties are checked on every cycle:

- the forced error levels and cleared insertion flags that follow a cycle of low `blk_lock`;
- that no flag appears unless the machine was locked;
- that `frame_lock` never follows a cycle of lost block lock;
- that `lane_status` holds across idle cycles;
- that `pyld_ins` never repeats in back-to-back cycles.

Only the bench scenarios can show which word position triggers which flag, the exact count of synchronization words for lock and for loss, the clearing of the miss count by a good word, and the captured status values.

// File: rtl/ifs_pkg.sv
package ifs_pkg;

    localparam logic [63:0] SYNC_WORD = 64'h78F6_78F6_78F6_78F6;
    localparam logic [5:0]  TYPE_SCR  = 6'b001010;
    localparam logic [5:0]  TYPE_SKIP = 6'b000111;
    localparam logic [5:0]  TYPE_DIAG = 6'b011001;
    localparam logic [57:0] SKIP_BODY = {2'b10, 56'h1E1E1E1E1E1E1E};

    typedef enum logic [1:0] {
        ST_SEARCH = 2'd0,
        ST_VERIFY = 2'd1,
        ST_LOCKED = 2'd2
    } fs_state_e;

    typedef struct packed {
        logic is_sync;
        logic is_skip;
        logic skip_ok;
        logic is_diag;
        logic is_scr;
    } word_class_t;

endpackage

// File: rtl/ifs_word_class.sv
module ifs_word_class
    import ifs_pkg::*;
(
    input  logic        ctrl,
    input  logic [63:0] data,
    output word_class_t cls
);
    logic [5:0] tcode;

    always_comb begin
        tcode       = data[63:58];
        cls.is_sync = ctrl && (data == SYNC_WORD);
        cls.is_skip = ctrl && (tcode == TYPE_SKIP);
        cls.skip_ok = ctrl && (tcode == TYPE_SKIP) && (data[57:0] == SKIP_BODY);
        cls.is_diag = ctrl && (tcode == TYPE_DIAG);
        cls.is_scr  = ctrl && (tcode == TYPE_SCR);
    end
endmodule

// File: rtl/ifs_frame_fsm.sv
module ifs_frame_fsm
    import ifs_pkg::*;
#(
    parameter int MF_LEN     = 8,
    parameter int LOCK_CNT   = 4,
    parameter int UNLOCK_CNT = 4
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        blk_lock,
    input  logic                        word_valid,
    input  logic                        is_sync,
    output fs_state_e                   state,
    output logic [$clog2(MF_LEN)-1:0]   pos,
    output logic                        frame_lock
);
    localparam int PW = $clog2(MF_LEN);
    localparam int GW = $clog2(LOCK_CNT + 1);
    localparam int BW = $clog2(UNLOCK_CNT + 1);
    localparam logic [PW-1:0] POS_LAST = PW'(MF_LEN - 1);

    fs_state_e     state_nxt;
    logic [PW-1:0] pos_nxt, pos_inc;
    logic [GW-1:0] good_q, good_nxt;
    logic [BW-1:0] miss_q, miss_nxt;

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state  <= ST_SEARCH;
            pos    <= '0;
            good_q <= '0;
            miss_q <= '0;
        end else begin
            state  <= state_nxt;
            pos    <= pos_nxt;
            good_q <= good_nxt;
            miss_q <= miss_nxt;
        end
    end

    // next state
    always_comb begin
        pos_inc   = (pos == POS_LAST) ? '0 : pos + 1'b1;
        state_nxt = state;
        pos_nxt   = pos;
        good_nxt  = good_q;
        miss_nxt  = miss_q;
        if (!blk_lock) begin
            state_nxt = ST_SEARCH;
            pos_nxt   = '0;
            good_nxt  = '0;
            miss_nxt  = '0;
        end else if (word_valid) begin
            unique case (state)
                ST_SEARCH: begin
                    if (is_sync) begin
                        state_nxt = ST_VERIFY;
                        pos_nxt   = PW'(1);
                        good_nxt  = GW'(1);
                    end
                end
                ST_VERIFY: begin
                    pos_nxt = pos_inc;
                    if (pos == '0) begin
                        if (!is_sync) begin
                            state_nxt = ST_SEARCH;
                            pos_nxt   = '0;
                            good_nxt  = '0;
                        end else if (good_q == GW'(LOCK_CNT - 1)) begin
                            state_nxt = ST_LOCKED;
                            good_nxt  = '0;
                            miss_nxt  = '0;
                        end else begin
                            good_nxt = good_q + 1'b1;
                        end
                    end
                end
                ST_LOCKED: begin
                    pos_nxt = pos_inc;
                    if (pos == '0) begin
                        if (is_sync) begin
                            miss_nxt = '0;
                        end else if (miss_q == BW'(UNLOCK_CNT - 1)) begin
                            state_nxt = ST_SEARCH;
                            pos_nxt   = '0;
                            miss_nxt  = '0;
                        end else begin
                            miss_nxt = miss_q + 1'b1;
                        end
                    end
                end
                default: state_nxt = ST_SEARCH;
            endcase
        end
    end

    // outputs
    always_comb frame_lock = (state == ST_LOCKED);
endmodule

// File: rtl/ifs_flag_gen.sv
module ifs_flag_gen
    import ifs_pkg::*;
#(
    parameter int MF_LEN = 8
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      blk_lock,
    input  logic                      word_valid,
    input  logic                      locked,
    input  logic [$clog2(MF_LEN)-1:0] pos,
    input  word_class_t               cls,
    input  logic [1:0]                diag_st,
    output logic                      sync_err,
    output logic                      skip_ins,
    output logic                      pyld_ins,
    output logic                      skip_err,
    output logic                      diag_err,
    output logic [1:0]                lane_status
);
    localparam int PW = $clog2(MF_LEN);
    localparam logic [PW-1:0] POS_SYNC = PW'(0);
    localparam logic [PW-1:0] POS_SKIP = PW'(2);
    localparam logic [PW-1:0] POS_DIAG = PW'(MF_LEN - 1);

    logic chk;
    always_comb chk = word_valid && locked;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sync_err    <= 1'b0;
            skip_ins    <= 1'b0;
            pyld_ins    <= 1'b0;
            skip_err    <= 1'b0;
            diag_err    <= 1'b0;
            lane_status <= 2'b00;
        end else if (!blk_lock) begin
            sync_err <= 1'b1;
            skip_err <= 1'b1;
            diag_err <= 1'b1;
            skip_ins <= 1'b0;
            pyld_ins <= 1'b0;
        end else begin
            sync_err <= chk && (pos == POS_SYNC) && !cls.is_sync;
            skip_ins <= chk && (pos != POS_SKIP) && cls.is_skip;
            pyld_ins <= chk && (pos == POS_SKIP) && !cls.is_skip;
            skip_err <= chk && (pos == POS_SKIP) && cls.is_skip && !cls.skip_ok;
            diag_err <= chk && (pos == POS_DIAG) && !cls.is_diag;
            if (chk && (pos == POS_DIAG) && cls.is_diag)
                lane_status <= diag_st;
        end
    end
endmodule

// File: rtl/ifs_frame_sync.sv
module ifs_frame_sync
    import ifs_pkg::*;
#(
    parameter int MF_LEN     = 8,
    parameter int LOCK_CNT   = 4,
    parameter int UNLOCK_CNT = 4
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        blk_lock,
    input  logic        word_valid,
    input  logic        word_ctrl,
    input  logic [63:0] word_data,
    output logic        frame_lock,
    output logic        sync_err,
    output logic        skip_ins,
    output logic        pyld_ins,
    output logic        skip_err,
    output logic        diag_err,
    output logic [1:0]  lane_status
);
    localparam int PW = $clog2(MF_LEN);

    word_class_t   cls;
    fs_state_e     state;
    logic [PW-1:0] pos;
    logic          unused_scr;

    ifs_word_class u_class (
        .ctrl (word_ctrl),
        .data (word_data),
        .cls  (cls)
    );

    assign unused_scr = cls.is_scr;

    ifs_frame_fsm #(
        .MF_LEN     (MF_LEN),
        .LOCK_CNT   (LOCK_CNT),
        .UNLOCK_CNT (UNLOCK_CNT)
    ) u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .blk_lock   (blk_lock),
        .word_valid (word_valid),
        .is_sync    (cls.is_sync),
        .state      (state),
        .pos        (pos),
        .frame_lock (frame_lock)
    );

    ifs_flag_gen #(
        .MF_LEN (MF_LEN)
    ) u_flags (
        .clk         (clk),
        .rst_n       (rst_n),
        .blk_lock    (blk_lock),
        .word_valid  (word_valid),
        .locked      (state == ST_LOCKED),
        .pos         (pos),
        .cls         (cls),
        .diag_st     (word_data[33:32]),
        .sync_err    (sync_err),
        .skip_ins    (skip_ins),
        .pyld_ins    (pyld_ins),
        .skip_err    (skip_err),
        .diag_err    (diag_err),
        .lane_status (lane_status)
    );
endmodule

// File: rtl/ifs_frame_sync_chk.sv
module ifs_frame_sync_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       blk_lock,
    input logic       word_valid,
    input logic       frame_lock,
    input logic       sync_err,
    input logic       skip_ins,
    input logic       pyld_ins,
    input logic       skip_err,
    input logic       diag_err,
    input logic [1:0] lane_status
);
    p_blk_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && !$past(blk_lock)) |->
        (sync_err && skip_err && diag_err && !skip_ins && !pyld_ins && !frame_lock));

    p_lock_needs_blk_r8: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && frame_lock) |-> $past(blk_lock));

    p_flag_needs_lock_r10: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(blk_lock) &&
         (sync_err || skip_ins || pyld_ins || skip_err || diag_err)) |-> $past(frame_lock));

    p_slot_excl_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !(skip_ins && pyld_ins));

    p_pyld_single_r4: assert property (@(posedge clk) disable iff (!rst_n)
        pyld_ins |=> !pyld_ins);

    p_status_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && !$past(word_valid)) |-> $stable(lane_status));

    p_lock_on_word_r1: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $rose(frame_lock)) |-> $past(word_valid));
endmodule

bind ifs_frame_sync ifs_frame_sync_chk u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .blk_lock    (blk_lock),
    .word_valid  (word_valid),
    .frame_lock  (frame_lock),
    .sync_err    (sync_err),
    .skip_ins    (skip_ins),
    .pyld_ins    (pyld_ins),
    .skip_err    (skip_err),
    .diag_err    (diag_err),
    .lane_status (lane_status)
);

// File: tb/ifs_frame_sync_bench.sv
module ifs_frame_sync_bench;
    localparam int CLK_PERIOD = 10;
    localparam int MF = 8;

    localparam logic [63:0] SYNC_W  = 64'h78F6_78F6_78F6_78F6;
    localparam logic [5:0]  T_SCR   = 6'b001010;
    localparam logic [5:0]  T_SKIP  = 6'b000111;
    localparam logic [5:0]  T_DIAG  = 6'b011001;
    localparam logic [57:0] SK_BODY = {2'b10, 56'h1E1E1E1E1E1E1E};

    typedef struct {
        logic       se, si, pi, ke, de, lk;
        logic [1:0] st;
        string      tag;
    } exp_t;

    typedef enum int {V_GOOD, V_BADSYNC, V_NOSKIP, V_SKIPBAD, V_EXTRASKIP, V_BADDIAG} var_e;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        blk_lock = 1'b0;
    logic        word_valid = 1'b0;
    logic        word_ctrl = 1'b0;
    logic [63:0] word_data = '0;
    logic        frame_lock, sync_err, skip_ins, pyld_ins, skip_err, diag_err;
    logic [1:0]  lane_status;

    int   total = 0;
    int   bad = 0;
    bit   done = 1'b0;
    logic [1:0] exp_status = 2'b00;
    exp_t q[$];

    always #(CLK_PERIOD/2) clk = ~clk;

    ifs_frame_sync #(.MF_LEN(MF)) u_ifs_frame_sync (
        .clk (clk), .rst_n (rst_n), .blk_lock (blk_lock),
        .word_valid (word_valid), .word_ctrl (word_ctrl), .word_data (word_data),
        .frame_lock (frame_lock), .sync_err (sync_err), .skip_ins (skip_ins),
        .pyld_ins (pyld_ins), .skip_err (skip_err), .diag_err (diag_err),
        .lane_status (lane_status)
    );

    task automatic check(input logic ok, input string tag, input string what,
                         input logic [1:0] act, input logic [1:0] expv);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s actual=%0d expected=%0d at %0t", tag, what, act, expv, $time);
        end
    endtask

    task automatic send(input logic blk, input logic ctrl, input logic [63:0] d,
                        input logic e_se, input logic e_si, input logic e_pi,
                        input logic e_ke, input logic e_de, input logic e_lk,
                        input string tag);
        exp_t e;
        blk_lock   = blk;
        word_valid = 1'b1;
        word_ctrl  = ctrl;
        word_data  = d;
        e.se = e_se; e.si = e_si; e.pi = e_pi; e.ke = e_ke; e.de = e_de; e.lk = e_lk;
        e.st = exp_status; e.tag = tag;
        q.push_back(e);
        @(negedge clk);
        word_valid = 1'b0;
    endtask

    task automatic frame(input var_e v, input bit lkb, input bit lka, input logic [1:0] st);
        logic [63:0] d;
        for (int p = 0; p < MF; p++) begin
            if (p == 0) begin
                if (v == V_BADSYNC)
                    send(1, 1, 64'h0123_4567_89AB_CDEF, lkb, 0, 0, 0, 0, lka, "R2 R9");
                else
                    send(1, 1, SYNC_W, 0, 0, 0, 0, 0, lka, "R1");
            end else if (p == 1) begin
                send(1, 1, {T_SCR, 58'h0ABC}, 0, 0, 0, 0, 0, lka, "R3 scr");
            end else if (p == 2) begin
                if (v == V_NOSKIP)
                    send(1, 0, 64'hDEAD_BEEF_0000_0002, 0, 0, lka, 0, 0, lka, "R4 R10");
                else if (v == V_SKIPBAD)
                    send(1, 1, {T_SKIP, SK_BODY ^ 58'h1}, 0, 0, 0, lka, 0, lka, "R5");
                else
                    send(1, 1, {T_SKIP, SK_BODY}, 0, 0, 0, 0, 0, lka, "R5 good");
            end else if (p == MF - 1) begin
                if (v == V_BADDIAG) begin
                    d = 64'h0;
                    d[33:32] = st;
                    send(1, 0, d, 0, 0, 0, 0, lka, lka, "R6");
                end else begin
                    d = {T_DIAG, 58'h0};
                    d[33:32] = st;
                    if (lka) exp_status = st;
                    send(1, 1, d, 0, 0, 0, 0, 0, lka, "R7");
                end
            end else begin
                if (v == V_EXTRASKIP && p == 4)
                    send(1, 1, {T_SKIP, SK_BODY}, 0, lka, 0, 0, 0, lka, "R3");
                else
                    send(1, 0, 64'hA5A5_0000_0000_0000 | 64'(p), 0, 0, 0, 0, 0, lka, "R10 data");
            end
        end
    endtask

    // monitor: compare outputs for each word one cycle after it
    initial begin
        forever begin
            logic v;
            exp_t e;
            @(posedge clk);
            v = word_valid;
            @(negedge clk);
            if (v && rst_n) begin
                if (q.size() == 0) begin
                    check(1'b0, "scoreboard", "empty queue", 2'd0, 2'd1);
                end else begin
                    e = q.pop_front();
                    check(sync_err == e.se, e.tag, "sync_err", {1'b0, sync_err}, {1'b0, e.se});
                    check(skip_ins == e.si, e.tag, "skip_ins", {1'b0, skip_ins}, {1'b0, e.si});
                    check(pyld_ins == e.pi, e.tag, "pyld_ins", {1'b0, pyld_ins}, {1'b0, e.pi});
                    check(skip_err == e.ke, e.tag, "skip_err", {1'b0, skip_err}, {1'b0, e.ke});
                    check(diag_err == e.de, e.tag, "diag_err", {1'b0, diag_err}, {1'b0, e.de});
                    check(frame_lock == e.lk, e.tag, "frame_lock", {1'b0, frame_lock}, {1'b0, e.lk});
                    check(lane_status == e.st, e.tag, "lane_status", lane_status, e.st);
                end
            end
        end
    end

    initial begin
        #(CLK_PERIOD * 20000);
        if (!done) begin
            check(1'b0, "watchdog", "timeout", 2'd0, 2'd1);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        blk_lock = 1'b1;
        @(negedge clk);
        // reset state (R7, R1)
        check(lane_status == 2'b00, "R7", "reset lane_status", lane_status, 2'b00);
        check(frame_lock == 1'b0, "R1", "reset frame_lock", {1'b0, frame_lock}, 2'd0);
        check((sync_err | skip_ins | pyld_ins | skip_err | diag_err) == 1'b0, "R10",
              "reset flags", {1'b0, sync_err}, 2'd0);

        // R1/R10: verify, restart on a miss, then lock
        frame(V_NOSKIP, 0, 0, 2'b11);
        frame(V_GOOD,   0, 0, 2'b11);
        frame(V_BADSYNC, 0, 0, 2'b11);
        frame(V_GOOD, 0, 0, 2'b11);
        frame(V_GOOD, 0, 0, 2'b11);
        frame(V_GOOD, 0, 0, 2'b11);
        frame(V_GOOD, 0, 1, 2'b11);

        // locked checks R3..R7
        frame(V_GOOD, 1, 1, 2'b10);
        repeat (2) @(negedge clk);   // idle cycles, status holds (R7)
        frame(V_NOSKIP, 1, 1, 2'b01);
        frame(V_SKIPBAD, 1, 1, 2'b01);
        frame(V_EXTRASKIP, 1, 1, 2'b10);
        frame(V_BADDIAG, 1, 1, 2'b11);
        frame(V_GOOD, 1, 1, 2'b01);

        // R9: three misses, recovery, then four misses
        frame(V_BADSYNC, 1, 1, 2'b11);
        frame(V_BADSYNC, 1, 1, 2'b10);
        frame(V_BADSYNC, 1, 1, 2'b11);
        frame(V_GOOD,    1, 1, 2'b11);
        frame(V_BADSYNC, 1, 1, 2'b00);
        frame(V_BADSYNC, 1, 1, 2'b00);
        frame(V_BADSYNC, 1, 1, 2'b00);
        frame(V_BADSYNC, 1, 0, 2'b10);

        // relock
        frame(V_GOOD, 0, 0, 2'b00);
        frame(V_GOOD, 0, 0, 2'b00);
        frame(V_GOOD, 0, 0, 2'b00);
        frame(V_GOOD, 0, 1, 2'b01);

        // R8: block lock lost while locked
        send(0, 1, SYNC_W, 1, 0, 0, 1, 1, 0, "R8");
        send(0, 1, {T_SKIP, SK_BODY}, 1, 0, 0, 1, 1, 0, "R8");
        send(0, 1, {T_DIAG, 58'h1_0000_0000}, 1, 0, 0, 1, 1, 0, "R8");
        blk_lock = 1'b1;
        @(negedge clk);
        frame(V_NOSKIP, 0, 0, 2'b10);
        frame(V_GOOD, 0, 0, 2'b10);
        frame(V_GOOD, 0, 0, 2'b10);
        frame(V_GOOD, 0, 1, 2'b10);

        repeat (3) @(negedge clk);
        check(q.size() == 0, "R1", "queue drained", 2'(q.size()), 2'd0);
        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule